// File: doc/BRIEF.md
# QRSS Pattern Sync Detector

This block checks a recovered receive bit stream against the quasi-random test sequence. That sequence is a 20-stage maximal-length shift-register sequence with its long zero runs broken up. The detector builds its own reference by loading received bits into a local shift register, then lets that register run freely and compares each later received bit with the bit it predicts. Errors are counted over consecutive 128-bit windows. A window with few enough errors declares lock. Once locked, a window with too many errors drops lock and starts a new seeding.

The main output is an active-low indicator. It stays high while the detector is unlocked, disabled or facing loss of signal. Once lock is reached it goes low, and while locked it rises for exactly half a bit period on every mismatching bit. An external error counter can count those pulses. The half-bit pulse is built from a twice-per-bit tick, so all logic runs on one system clock. A select input chooses which half of the bit period carries the pulse.

For a host, the block also provides a lock status bit, a sticky flag that records any change of lock status until a clear command, and a maskable interrupt taken from that flag.

Top module: `qrss_sync_det`

## Requirements
- R1: After 20 sampled bits have been loaded as the seed, the next 128 sampled bits are compared with the prediction. If that window holds fewer than 4 mismatches, `in_sync` becomes 1.
- R2: A comparison window before lock that holds 4 or more mismatches leaves `in_sync` at 0, and the detector reseeds from the next 20 sampled bits.
- R3: `miss_ind` is 1 whenever `in_sync` is 0, and 0 while locked except during error pulses. Out of reset, `miss_ind` is 1.
- R4: While locked, each mismatching bit drives `miss_ind` to 1 for one half-bit period. With `edge_sel` = 0, the pulse occupies the half that starts at the sampling tick (recovered clock high). With `edge_sel` = 1, it occupies the following half (recovered clock low).
- R5: While locked, a window with at most 4 mismatches keeps lock. A window with 5 or more drops `in_sync` to 0 at that window's last bit, and the detector reseeds.
- R6: While `los` is 1, `miss_ind` is held at 1, `in_sync` is 0 and sampled bits are ignored. Seeding restarts once `los` returns to 0.
- R7: While `enable` is 0, the detector is idle: `in_sync` is 0 and `miss_ind` is 1. Seeding restarts once `enable` returns to 1.
- R8: `sync_chg` sets on every change of `in_sync` and stays set until a one-cycle `host_clr` pulse. A change detected after a clear sets the flag again.
- R9: `irq` is 1 exactly when `sync_chg` is 1 and `irq_mask` is 0.
- R10: The prediction for each bit is p = s(n-17) XOR s(n-20) over the register contents. The compared bit is forced to 1 when the last 14 register entries are all 0. The register shifts in p, not the forced bit. During seeding it shifts in the received bit.
- R11: Two `half_tick` pulses make one bit period. The first tick after reset, and every second tick after it, is the sampling tick at which `rx_data` is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Detector enable (test-sequence mode selected) |
| los | input | 1 | Loss-of-signal flag |
| half_tick | input | 1 | One-cycle pulse, two per bit period |
| rx_data | input | 1 | Received data, taken on sampling ticks |
| edge_sel | input | 1 | Error pulse phase select |
| host_clr | input | 1 | One-cycle clear of the change flag |
| irq_mask | input | 1 | 1 blocks the interrupt |
| miss_ind | output | 1 | Active-low lock / error indicator |
| in_sync | output | 1 | Lock status |
| sync_chg | output | 1 | Sticky lock-change flag |
| irq | output | 1 | Lock-change interrupt |

## Verification
The stream starts from a generator state with a single 1, so the first bits run through long zero stretches. Acquisition is therefore tried on forced bits and on seeds that fail, before a clean lock shows that the prediction and the zero-run rule match. Windows aligned to the detector's own window boundary carry 3 and 4 mismatches before lock, and 4 and 5 mismatches after lock. This pins down both thresholds at their edges. Single errors under each `edge_sel` value show which half-bit carries the pulse. Loss of signal, disabling, host clears and masking are applied in turn to separate the override paths from the flag and interrupt logic.

// File: rtl/qrss_det_pkg.sv
// Package: shared types for the test-sequence sync detector.
// Assumes nothing beyond IEEE 1800-2017 enumerations.
package qrss_det_pkg;

    // Detector phase: loading the seed, hunting for lock, locked.
    typedef enum logic [1:0] {
        ST_SEED = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } det_state_t;

endpackage

// File: rtl/qrss_refgen.sv
// Module: local reference generator.
// Holds the last LEN reference bits. While load_rx is high it shifts in
// received bits (self-seeding); otherwise it shifts in its own feedback.
// exp_bit is the predicted line bit: the feedback value, forced to 1 when
// the newest JAM entries of the history are all zero.
// Assumes shift_en is a one-cycle pulse per received bit.
module qrss_refgen #(
    parameter int LEN = 20,
    parameter int TAP = 17,
    parameter int JAM = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic load_rx,
    input  logic rx_bit,
    output logic exp_bit
);

    logic [LEN-1:0] hist;
    logic           fb_bit;
    logic           zero_run;

    // Feedback from the two tap stages of the history.
    assign fb_bit   = hist[TAP-1] ^ hist[LEN-1];
    // The newest JAM stages hold zeros only.
    assign zero_run = ~|hist[JAM-1:0];
    // Predicted bit after zero-run suppression.
    assign exp_bit  = fb_bit | zero_run;

    // History shift: received bit while seeding, feedback otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[LEN-2:0], (load_rx ? rx_bit : fb_bit)};
        end
    end

endmodule

// File: rtl/qrss_sync_fsm.sv
// Module: seeding / window / lock state machine.
// Counts SEED_BITS seed bits, then counts mismatches over WIN_BITS-bit
// windows. Hunting locks when a window ends with fewer than ACQ_LIMIT
// mismatches. Locked drops when a window ends with more than LOSS_LIMIT.
// Assumes sample is a one-cycle pulse per bit and mismatch is valid with it.
module qrss_sync_fsm
    import qrss_det_pkg::*;
#(
    parameter int SEED_BITS  = 20,
    parameter int WIN_BITS   = 128,
    parameter int ACQ_LIMIT  = 4,
    parameter int LOSS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sample,
    input  logic mismatch,
    output logic load_rx,
    output logic shift_en,
    output logic in_sync,
    output logic err_hit
);

    localparam int CNT_MAX = (WIN_BITS > SEED_BITS) ? WIN_BITS : SEED_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int ERR_W   = $clog2(WIN_BITS + 1);

    localparam logic [CNT_W-1:0] SEED_LAST = CNT_W'(SEED_BITS - 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_BITS - 1);
    localparam logic [ERR_W:0]   ACQ_LIM   = (ERR_W+1)'(ACQ_LIMIT);
    localparam logic [ERR_W:0]   LOSS_LIM  = (ERR_W+1)'(LOSS_LIMIT);

    det_state_t       state;
    logic [CNT_W-1:0] bit_cnt;
    logic [ERR_W-1:0] err_cnt;
    logic [ERR_W:0]   err_tot;
    logic             win_end;

    // Mismatch total for the window including the current bit.
    assign err_tot  = {1'b0, err_cnt} + {{ERR_W{1'b0}}, mismatch};
    // Current bit is the last of a comparison window.
    assign win_end  = (bit_cnt == WIN_LAST);

    // Outputs decoded from the state.
    assign load_rx  = (state == ST_SEED);
    assign shift_en = sample & active;
    assign in_sync  = (state == ST_LOCK);
    assign err_hit  = sample & active & (state == ST_LOCK) & mismatch;

    // Phase sequencing, bit counting and error counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state   <= ST_SEED;
            bit_cnt <= '0;
            err_cnt <= '0;
        end else if (sample) begin
            case (state)
                ST_SEED: begin
                    if (bit_cnt == SEED_LAST) begin
                        state   <= ST_HUNT;
                        bit_cnt <= '0;
                        err_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_HUNT: begin
                    if (win_end) begin
                        state   <= (err_tot < ACQ_LIM) ? ST_LOCK : ST_SEED;
                        bit_cnt <= '0;
                        err_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        err_cnt <= err_tot[ERR_W-1:0];
                    end
                end
                ST_LOCK: begin
                    if (win_end) begin
                        if (err_tot > LOSS_LIM) begin
                            state <= ST_SEED;
                        end
                        bit_cnt <= '0;
                        err_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        err_cnt <= err_tot[ERR_W-1:0];
                    end
                end
                default: begin
                    state   <= ST_SEED;
                    bit_cnt <= '0;
                    err_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/qrss_err_pulse.sv
// Module: half-bit phase tracking and indicator output.
// Tracks the recovered clock phase from half_tick (first tick after reset
// starts the high phase and is the sampling tick). An error hit on the
// sampling tick becomes a pulse in the high half (edge_sel = 0) or in the
// following low half (edge_sel = 1). The indicator is registered.
module qrss_err_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic edge_sel,
    input  logic hit,
    input  logic enable,
    input  logic los,
    input  logic in_sync,
    output logic sample,
    output logic miss_ind
);

    logic phase_hi;
    logic pulse_q;
    logic pend_q;

    // A tick seen in the low phase starts a new bit: sampling point.
    assign sample = half_tick & ~phase_hi;

    // Recovered clock phase toggles on every half tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_hi <= 1'b0;
        end else if (half_tick) begin
            phase_hi <= ~phase_hi;
        end
    end

    // Pulse placement in the chosen half of the bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (half_tick) begin
            if (!phase_hi) begin
                pulse_q <= hit & ~edge_sel;
                pend_q  <= hit &  edge_sel;
            end else begin
                pulse_q <= pend_q;
                pend_q  <= 1'b0;
            end
        end
    end

    // Active-low indicator: high when off, no signal, unlocked or error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_ind <= 1'b1;
        end else begin
            miss_ind <= ~enable | los | ~in_sync | pulse_q;
        end
    end

endmodule

// File: rtl/qrss_host_status.sv
// Module: sticky lock-change flag and maskable interrupt.
// The flag sets one cycle after in_sync changes and clears on host_clr;
// a change seen after the clear sets it again.
module qrss_host_status (
    input  logic clk,
    input  logic rst_n,
    input  logic in_sync,
    input  logic host_clr,
    input  logic irq_mask,
    output logic sync_chg,
    output logic irq
);

    logic sync_d;

    // Previous lock status for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_d <= 1'b0;
        end else begin
            sync_d <= in_sync;
        end
    end

    // Sticky change flag, a detected change wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_chg <= 1'b0;
        end else begin
            sync_chg <= (in_sync ^ sync_d) | (sync_chg & ~host_clr);
        end
    end

    // Interrupt follows the flag unless masked.
    assign irq = sync_chg & ~irq_mask;

endmodule

// File: rtl/qrss_sync_det.sv
// Module: test-sequence sync detector (top).
// Joins the reference generator, the window state machine, the pulse
// stage and the host status. Assumes half_tick arrives twice per bit and
// rx_data is stable on the sampling tick.
module qrss_sync_det #(
    parameter int PRBS_LEN   = 20,
    parameter int PRBS_TAP   = 17,
    parameter int JAM_ZEROS  = 14,
    parameter int WIN_BITS   = 128,
    parameter int ACQ_LIMIT  = 4,
    parameter int LOSS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic los,
    input  logic half_tick,
    input  logic rx_data,
    input  logic edge_sel,
    input  logic host_clr,
    input  logic irq_mask,
    output logic miss_ind,
    output logic in_sync,
    output logic sync_chg,
    output logic irq
);

    logic active;
    logic sample;
    logic exp_bit;
    logic mismatch;
    logic load_rx;
    logic shift_en;
    logic err_hit;

    // Detector runs only when enabled and a signal is present.
    assign active   = enable & ~los;
    // Received bit disagrees with the prediction.
    assign mismatch = rx_data ^ exp_bit;

    qrss_refgen #(
        .LEN (PRBS_LEN),
        .TAP (PRBS_TAP),
        .JAM (JAM_ZEROS)
    ) i_refgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .load_rx  (load_rx),
        .rx_bit   (rx_data),
        .exp_bit  (exp_bit)
    );

    qrss_sync_fsm #(
        .SEED_BITS  (PRBS_LEN),
        .WIN_BITS   (WIN_BITS),
        .ACQ_LIMIT  (ACQ_LIMIT),
        .LOSS_LIMIT (LOSS_LIMIT)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .sample   (sample),
        .mismatch (mismatch),
        .load_rx  (load_rx),
        .shift_en (shift_en),
        .in_sync  (in_sync),
        .err_hit  (err_hit)
    );

    qrss_err_pulse i_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .edge_sel  (edge_sel),
        .hit       (err_hit),
        .enable    (enable),
        .los       (los),
        .in_sync   (in_sync),
        .sample    (sample),
        .miss_ind  (miss_ind)
    );

    qrss_host_status i_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_sync  (in_sync),
        .host_clr (host_clr),
        .irq_mask (irq_mask),
        .sync_chg (sync_chg),
        .irq      (irq)
    );

endmodule

// File: rtl/qrss_sync_det_chk.sv
// Module: property checker for the sync detector, bound to the top.
module qrss_sync_det_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic los,
    input logic in_sync,
    input logic miss_ind,
    input logic sync_chg
);

    // R3: unlocked in the previous cycle means the indicator is high.
    p_ind_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_sync) |-> miss_ind);

    // R6: loss of signal holds the indicator high and drops lock.
    p_los_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(los) |-> (miss_ind && !in_sync));

    // R7: a disabled detector reports no lock.
    p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> !in_sync);

    // R8: every lock status change leaves the sticky flag set.
    p_change_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync != $past(in_sync)) |=> sync_chg);

endmodule

bind qrss_sync_det qrss_sync_det_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .los      (los),
    .in_sync  (in_sync),
    .miss_ind (miss_ind),
    .sync_chg (sync_chg)
);

// File: tb/test_qrss_sync_det.sv
// Bench: scoreboard for the sync detector. The driver computes the expected
// outputs per half-bit from a requirement model and queues them; a monitor
// pops and compares once the outputs have settled.
module test_qrss_sync_det;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, enable, los, half_tick, rx_data, edge_sel, host_clr, irq_mask;
    logic miss_ind, in_sync, sync_chg, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    qrss_sync_det i_qrss_sync_det (
        .clk(clk), .rst_n(rst_n), .enable(enable), .los(los),
        .half_tick(half_tick), .rx_data(rx_data), .edge_sel(edge_sel),
        .host_clr(host_clr), .irq_mask(irq_mask), .miss_ind(miss_ind),
        .in_sync(in_sync), .sync_chg(sync_chg), .irq(irq)
    );

    typedef struct {
        logic  ind;
        logic  sync;
        logic  chg;
        logic  irq;
        string req;
    } exp_t;

    exp_t  sb_q[$];
    event  chk_ev;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R11";

    logic [19:0] gen_st;
    int          m_state, m_cnt, m_err;
    logic [19:0] m_hist;
    logic        m_chg, m_pend, m_pulse;

    task automatic cmp(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Monitor: pop expected items and compare with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                cmp(e.req, "miss_ind", miss_ind, e.ind);
                cmp(e.req, "in_sync",  in_sync,  e.sync);
                cmp(e.req, "sync_chg", sync_chg, e.chg);
                cmp(e.req, "irq",      irq,      e.irq);
            end
        end
    end

    // One half-bit: drive the tick, update the model, queue the expectation.
    task automatic half(input bit is_sample, input logic rx, input bit clr);
        logic raw, expb, e, hit, old_sync;
        int   tot;
        exp_t x;
        @(negedge clk);
        half_tick = 1'b1;
        host_clr  = clr;
        if (is_sample) rx_data = rx;
        if (clr) m_chg = 1'b0;
        old_sync = (m_state == 2);
        if (is_sample) begin
            hit = 1'b0;
            if (!enable || los) begin
                m_state = 0; m_cnt = 0; m_err = 0;
            end else begin
                raw  = m_hist[16] ^ m_hist[19];
                expb = raw | (m_hist[13:0] == 14'd0);
                e    = (rx != expb);
                if (m_state == 0) begin
                    m_hist = {m_hist[18:0], rx};
                    if (m_cnt == 19) begin m_state = 1; m_cnt = 0; m_err = 0; end
                    else m_cnt++;
                end else begin
                    m_hist = {m_hist[18:0], raw};
                    hit = (m_state == 2) && e;
                    if (m_cnt == 127) begin
                        tot = m_err + int'(e);
                        if (m_state == 1) m_state = (tot < 4) ? 2 : 0;
                        else if (tot > 4) m_state = 0;
                        m_cnt = 0; m_err = 0;
                    end else begin
                        m_err = m_err + int'(e);
                        m_cnt++;
                    end
                end
            end
            m_pulse = hit & ~edge_sel;
            m_pend  = hit & edge_sel;
        end else begin
            m_pulse = m_pend;
            m_pend  = 1'b0;
        end
        if ((m_state == 2) != old_sync) m_chg = 1'b1;
        @(negedge clk);
        half_tick = 1'b0;
        host_clr  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        x.ind  = ~enable | los | (m_state != 2) | m_pulse;
        x.sync = (m_state == 2);
        x.chg  = m_chg;
        x.irq  = m_chg & ~irq_mask;
        x.req  = cur_req;
        sb_q.push_back(x);
        -> chk_ev;
        #1;
    endtask

    // One line bit from the bench generator, optionally inverted.
    task automatic send_bit(input bit flip, input bit clr);
        logic raw, lb;
        raw    = gen_st[16] ^ gen_st[19];
        lb     = raw | (gen_st[13:0] == 14'd0);
        gen_st = {gen_st[18:0], raw};
        half(1'b1, lb ^ flip, clr);
        half(1'b0, 1'b0, 1'b0);
    endtask

    // Clean bits until the model reaches a phase at a window start.
    task automatic run_until(input int st, input int maxb);
        int n = 0;
        while (!(m_state == st && m_cnt == 0) && n < maxb) begin
            send_bit(1'b0, 1'b0);
            n++;
        end
    endtask

    // One full window with nflip mismatches at every tenth bit.
    task automatic run_window(input int nflip);
        for (int i = 0; i < 128; i++)
            send_bit((i % 10 == 0) && (i / 10 < nflip), 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; los = 1'b0; half_tick = 1'b0; rx_data = 1'b0;
        edge_sel = 1'b0; host_clr = 1'b0; irq_mask = 1'b0;
        gen_st = 20'h00001;
        m_state = 0; m_cnt = 0; m_err = 0; m_hist = '0; m_chg = 0; m_pend = 0; m_pulse = 0;
        repeat (4) @(negedge clk);
        // R11 reset state
        cmp("R11", "miss_ind reset", miss_ind, 1'b1);
        cmp("R11", "in_sync reset",  in_sync,  1'b0);
        cmp("R11", "sync_chg reset", sync_chg, 1'b0);
        cmp("R11", "irq reset",      irq,      1'b0);
        rst_n = 1'b1;

        // R10 acquisition through forced zero-run bits, then R1 lock
        cur_req = "R10";
        run_until(2, 6000);
        cmp("R1", "locked after clean window", in_sync, 1'b1);
        cmp("R3", "indicator low when locked", miss_ind, 1'b0);
        cmp("R8", "flag set on gain", sync_chg, 1'b1);
        cmp("R9", "irq unmasked", irq, 1'b1);

        // R8 host clear
        cur_req = "R8";
        send_bit(1'b0, 1'b1);
        cmp("R8", "flag cleared", sync_chg, 1'b0);
        cmp("R9", "irq follows flag", irq, 1'b0);

        // R4 single errors in both pulse phases
        cur_req = "R4";
        repeat (3) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        repeat (3) send_bit(1'b0, 1'b0);
        edge_sel = 1'b1;
        send_bit(1'b1, 1'b0);
        repeat (3) send_bit(1'b0, 1'b0);
        edge_sel = 1'b0;

        // R5 four mismatches keep lock, five drop it
        cur_req = "R5";
        run_until(2, 200);
        run_window(4);
        cmp("R5", "lock kept with 4", in_sync, 1'b1);
        irq_mask = 1'b1;
        run_window(5);
        cmp("R5", "lock lost with 5", in_sync, 1'b0);
        cmp("R8", "flag set on loss", sync_chg, 1'b1);
        cmp("R9", "irq masked", irq, 1'b0);
        irq_mask = 1'b0;
        send_bit(1'b0, 1'b1);

        // R1 hunt window with 3 mismatches locks
        cur_req = "R1";
        run_until(1, 200);
        run_window(3);
        cmp("R1", "lock with 3", in_sync, 1'b1);

        // R6 loss of signal
        cur_req = "R6";
        los = 1'b1;
        repeat (30) send_bit(1'b0, 1'b0);
        cmp("R6", "indicator held", miss_ind, 1'b1);
        cmp("R6", "lock dropped", in_sync, 1'b0);
        los = 1'b0;

        // R2 hunt window with 4 mismatches does not lock
        cur_req = "R2";
        run_until(1, 200);
        run_window(4);
        cmp("R2", "no lock with 4", in_sync, 1'b0);
        cmp("R3", "indicator high unlocked", miss_ind, 1'b1);

        // R7 disable
        cur_req = "R7";
        run_until(2, 400);
        cmp("R7", "relocked before disable", in_sync, 1'b1);
        enable = 1'b0;
        repeat (10) send_bit(1'b0, 1'b0);
        cmp("R7", "idle status", in_sync, 1'b0);
        cmp("R7", "idle indicator", miss_ind, 1'b1);
        enable = 1'b1;
        run_until(2, 400);
        cmp("R7", "relock after enable", in_sync, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule